// File: doc/BRIEF.md
# Circular Sample Buffer DMA Pointer

This block keeps the address pointer for a DMA channel that streams audio or telephony samples through a circular buffer in memory. Configuration supplies a base address and a buffer length counted in samples. Each time the bus master reports that a sample has been moved, the pointer advances by one sample. When it passes the last sample, it wraps back to the base address.

Alongside the address, the block raises single-cycle event pulses. One pulse marks every advance. One marks the advance that reaches the middle of the buffer, and one marks the advance that wraps at its end. Software can use the half and end pulses to refill one half of the buffer while the DMA works on the other. A fourth pulse reports each bus error. A bus error also freezes the pointer until the channel is disabled and enabled again. Latching these pulses into interrupt flags is done outside the block.

Top module: `circ_dma_ptr`

## Requirements
- R1: After reset the internal offset is 0, `cur_addr` equals `cfg_base`, and all four event outputs are 0.
- R2: An accepted sample advances the offset by one and pulses `ev_count` for exactly one cycle, in the cycle after the strobe. A sample is accepted when `xfer_done`=1, `cfg_en`=1, `cfg_wr`=0, `bus_err`=0, the length is valid and the channel is not frozen. `cur_addr` always equals `cfg_base + offset*SAMPLE_BYTES`.
- R3: `ev_half` pulses together with `ev_count` on the advance that moves the offset from `cfg_len/2-1` to `cfg_len/2`, and on no other advance.
- R4: The advance from offset `cfg_len-1` wraps the offset to 0 in the same step. It pulses `ev_end` together with `ev_count`, so `cur_addr` equals `cfg_base` in the cycle of the pulse.
- R5: `ev_buserr` pulses in the cycle after each cycle with `bus_err`=1. A transfer strobed in the same cycle as a bus error is discarded.
- R6: A bus error while `cfg_en`=1 freezes the channel. While frozen, `xfer_done` has no effect: no advance and no `ev_count`. Driving `cfg_en` low clears the freeze, and the channel restarts at offset 0 when `cfg_en` is driven high again.
- R7: A cycle with `cfg_wr`=1 or `cfg_en`=0 resets the offset to 0 and produces no count, half or end event. This holds even when `xfer_done`=1 in the same cycle.
- R8: A length that is odd or below 2 is invalid. With an invalid length, `xfer_done` is ignored and the offset stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Channel enable; low clears the offset and the freeze |
| cfg_wr | input | 1 | One-cycle strobe marking that base or length has been written |
| cfg_base | input | ADDR_W | Buffer base address in bytes |
| cfg_len | input | LEN_W | Buffer length in samples (even, at least 2) |
| xfer_done | input | 1 | One sample transferred by the bus master |
| bus_err | input | 1 | Bus error reported by the bus master |
| cur_addr | output | ADDR_W | Current sample address |
| ev_count | output | 1 | Pulse on every pointer advance |
| ev_half | output | 1 | Pulse on the advance that reaches the buffer midpoint |
| ev_end | output | 1 | Pulse on the advance that wraps the buffer |
| ev_buserr | output | 1 | Pulse after each bus error |

## Verification
A wrong offset shows at `cur_addr` in the first cycle after the faulty update. The address is formed combinationally from the offset register. A wrong offset also moves the half or end pulse by as many samples as the offset is off, so the error appears within one buffer length at most. A freeze flag that is stuck or lost shows on the next strobed sample: `ev_count` and the address either move when they should hold, or hold when they should move. A wrong length decode makes the wrap land on the wrong sample, which the bench catches at the first wrap.

// File: rtl/dma_ptr_pkg.sv
package dma_ptr_pkg;

   typedef struct packed {
      logic count;
      logic half;
      logic wrap;
      logic buserr;
   } dma_ev_t;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/dma_ptr_ctrl.sv
module dma_ptr_ctrl #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_en,
   input  logic             cfg_wr,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             xfer_done,
   input  logic             bus_err,
   output logic             step,
   output logic             clear,
   output logic             frozen
);

   localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);

   logic len_ok;
   logic frz_q;

   assign len_ok = (cfg_len[0] == 1'b0) && (cfg_len >= MIN_LEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frz_q <= 1'b0;
      else if (!cfg_en)
         frz_q <= 1'b0;
      else if (bus_err)
         frz_q <= 1'b1;
   end

   assign frozen = frz_q;
   assign clear  = !cfg_en || cfg_wr;
   assign step   = cfg_en && !cfg_wr && len_ok && !frz_q && xfer_done && !bus_err;

endmodule

// File: rtl/dma_ptr_offset.sv
module dma_ptr_offset #(
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             step,
   input  logic             clear,
   output logic [LEN_W-1:0] off,
   output logic             half_hit,
   output logic             end_hit
);

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [LEN_W-1:0] off_q;
   logic [LEN_W-1:0] half_idx;
   logic [LEN_W-1:0] last_idx;

   assign half_idx = (cfg_len >> 1) - ONE;
   assign last_idx = cfg_len - ONE;
   assign half_hit = (off_q == half_idx);
   assign end_hit  = (off_q >= last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         off_q <= '0;
      else if (clear)
         off_q <= '0;
      else if (step)
         off_q <= end_hit ? '0 : off_q + ONE;
   end

   assign off = off_q;

endmodule

// File: rtl/dma_ptr_events.sv
module dma_ptr_events
   import dma_ptr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    step,
   input  logic    half_hit,
   input  logic    end_hit,
   input  logic    bus_err,
   output dma_ev_t ev
);

   dma_ev_t ev_d;

   always_comb begin
      ev_d.count  = step;
      ev_d.half   = step && half_hit;
      ev_d.wrap   = step && end_hit;
      ev_d.buserr = bus_err;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ev <= '0;
      else
         ev <= ev_d;
   end

endmodule

// File: rtl/dma_ptr_addr.sv
module dma_ptr_addr
   import dma_ptr_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int LEN_W        = 12,
   parameter int SAMPLE_BYTES = 4
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);

   localparam int SHIFT = $clog2(SAMPLE_BYTES);

   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] byte_off;

   assign off_ext = ADDR_W'(off);

   generate
      if (is_pow2(SAMPLE_BYTES)) begin : g_shift
         assign byte_off = off_ext << SHIFT;
      end else begin : g_mult
         assign byte_off = off_ext * ADDR_W'(SAMPLE_BYTES);
      end
   endgenerate

   assign addr = base + byte_off;

endmodule

// File: rtl/circ_dma_ptr.sv
module circ_dma_ptr
   import dma_ptr_pkg::*;
#(
   parameter int ADDR_W       = 32,
   parameter int LEN_W        = 12,
   parameter int SAMPLE_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_wr,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic              xfer_done,
   input  logic              bus_err,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              ev_count,
   output logic              ev_half,
   output logic              ev_end,
   output logic              ev_buserr
);

   initial begin
      assert (SAMPLE_BYTES >= 1) else $error("SAMPLE_BYTES must be at least 1");
      assert (LEN_W >= 2 && LEN_W < ADDR_W) else $error("LEN_W must lie in 2..ADDR_W-1");
   end

   logic             step_w;
   logic             clear_w;
   logic             frozen_w;
   logic [LEN_W-1:0] off_w;
   logic             half_w;
   logic             end_w;
   dma_ev_t          ev_w;

   dma_ptr_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_en    (cfg_en),
      .cfg_wr    (cfg_wr),
      .cfg_len   (cfg_len),
      .xfer_done (xfer_done),
      .bus_err   (bus_err),
      .step      (step_w),
      .clear     (clear_w),
      .frozen    (frozen_w)
   );

   dma_ptr_offset #(.LEN_W(LEN_W)) u_off (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_len  (cfg_len),
      .step     (step_w),
      .clear    (clear_w),
      .off      (off_w),
      .half_hit (half_w),
      .end_hit  (end_w)
   );

   dma_ptr_events u_ev (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step_w),
      .half_hit (half_w),
      .end_hit  (end_w),
      .bus_err  (bus_err),
      .ev       (ev_w)
   );

   dma_ptr_addr #(
      .ADDR_W       (ADDR_W),
      .LEN_W        (LEN_W),
      .SAMPLE_BYTES (SAMPLE_BYTES)
   ) u_addr (
      .base (cfg_base),
      .off  (off_w),
      .addr (cur_addr)
   );

   assign ev_count  = ev_w.count;
   assign ev_half   = ev_w.half;
   assign ev_end    = ev_w.wrap;
   assign ev_buserr = ev_w.buserr;

endmodule

// File: rtl/circ_dma_ptr_chk.sv
module circ_dma_ptr_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_en,
   input logic              cfg_wr,
   input logic              xfer_done,
   input logic              bus_err,
   input logic [ADDR_W-1:0] cfg_base,
   input logic [ADDR_W-1:0] cur_addr,
   input logic              ev_count,
   input logic              ev_half,
   input logic              ev_end,
   input logic              ev_buserr,
   input logic              step,
   input logic              frozen,
   input logic [LEN_W-1:0]  off
);

   // R2: every accepted sample is reported one cycle later
   assert_count_follows_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> ev_count);

   // R2: no count pulse without an accepted sample
   assert_no_spurious_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> !ev_count);

   // R3, R4: midpoint and wrap pulses ride on a count pulse and never coincide
   assert_half_end_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_half && ev_end));
   assert_end_needs_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_end |-> ev_count);

   // R4: wrap pulse coincides with offset 0
   assert_end_wraps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_end |-> (off == '0) && (cur_addr == cfg_base));

   // R5: bus error reported next cycle
   assert_buserr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |=> ev_buserr);

   // R6: a frozen channel produces no count pulse
   assert_frozen_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frozen |=> !ev_count);

   // R6: bus error while enabled freezes
   assert_err_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && bus_err) |=> frozen);

   // R7: disable or configuration write clears the offset
   assert_clear_offset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en || cfg_wr) |=> (off == '0));

   // R7: offset holds when nothing is accepted and nothing clears it
   assert_offset_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !cfg_wr && !step) |=> $stable(off));

endmodule

bind circ_dma_ptr circ_dma_ptr_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_en    (cfg_en),
   .cfg_wr    (cfg_wr),
   .xfer_done (xfer_done),
   .bus_err   (bus_err),
   .cfg_base  (cfg_base),
   .cur_addr  (cur_addr),
   .ev_count  (ev_count),
   .ev_half   (ev_half),
   .ev_end    (ev_end),
   .ev_buserr (ev_buserr),
   .step      (step_w),
   .frozen    (frozen_w),
   .off       (off_w)
);

// File: tb/circ_dma_ptr_bench.sv
module circ_dma_ptr_bench;

   localparam int ADDR_W = 32;
   localparam int LEN_W  = 12;
   localparam int SB     = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_en = 1'b0;
   logic              cfg_wr = 1'b0;
   logic [ADDR_W-1:0] cfg_base = '0;
   logic [LEN_W-1:0]  cfg_len = '0;
   logic              xfer_done = 1'b0;
   logic              bus_err = 1'b0;
   logic [ADDR_W-1:0] cur_addr;
   logic              ev_count, ev_half, ev_end, ev_buserr;

   int n_vec = 0;
   int n_bad = 0;
   bit done_flag = 1'b0;

   // bench reference model
   int  m_off = 0;
   int  m_len = 0;
   logic [ADDR_W-1:0] m_base = '0;
   bit  m_frozen = 1'b0;

   always #2.5 clk = ~clk;

   circ_dma_ptr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SAMPLE_BYTES(SB)) u_circ_dma_ptr (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr),
      .cfg_base(cfg_base), .cfg_len(cfg_len), .xfer_done(xfer_done), .bus_err(bus_err),
      .cur_addr(cur_addr), .ev_count(ev_count), .ev_half(ev_half), .ev_end(ev_end),
      .ev_buserr(ev_buserr)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock: drive at falling edge, sample 1 ns after rising edge
   task automatic cyc(bit en, bit wr, bit done, bit err);
      @(negedge clk);
      cfg_en = en; cfg_wr = wr; xfer_done = done; bus_err = err;
      @(posedge clk);
      #1;
   endtask

   task automatic idle_low();
      @(negedge clk);
      cfg_wr = 1'b0; xfer_done = 1'b0; bus_err = 1'b0;
   endtask

   function automatic bit len_valid(int l);
      return (l % 2 == 0) && (l >= 2);
   endfunction

   task automatic configure(logic [ADDR_W-1:0] b, int l);
      @(negedge clk);
      cfg_base = b; cfg_len = LEN_W'(l);
      m_base = b; m_len = l; m_off = 0;
      cyc(1'b1, 1'b1, 1'b0, 1'b0);
      chk("R7 addr after cfg write", cur_addr, b);
   endtask

   // one strobed sample with full expectation from the model
   task automatic sample(string tag);
      bit acc, h, e;
      acc = !m_frozen && len_valid(m_len);
      h = acc && (m_off == m_len / 2 - 1);
      e = acc && (m_off == m_len - 1);
      if (acc) m_off = e ? 0 : m_off + 1;
      cyc(1'b1, 1'b0, 1'b1, 1'b0);
      chk({tag, " count"}, 32'(ev_count), 32'(acc));
      chk({tag, " half"},  32'(ev_half),  32'(h));
      chk({tag, " end"},   32'(ev_end),   32'(e));
      chk({tag, " addr"},  cur_addr, m_base + 32'(m_off * SB));
   endtask

   task automatic t_reset();
      cfg_base = 32'h0000_4000;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset addr",  cur_addr, 32'h0000_4000);
      chk("R1 reset events", {28'd0, ev_count, ev_half, ev_end, ev_buserr}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_full_wrap();
      configure(32'h0000_1000, 8);
      for (int i = 0; i < 8; i++) sample("R2 R3 R4 len8");
      chk("R4 base after wrap", cur_addr, 32'h0000_1000);
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R2 count only one cycle", 32'(ev_count), 32'd0);
      for (int i = 0; i < 5; i++) sample("R2 R3 second lap");
      idle_low();
   endtask

   task automatic t_gaps();
      configure(32'h0002_0000, 6);
      for (int i = 0; i < 6; i++) begin
         sample("R2 R3 R4 len6 gaps");
         cyc(1'b1, 1'b0, 1'b0, 1'b0);
         chk("R2 idle no count", 32'(ev_count), 32'd0);
         chk("R2 idle addr hold", cur_addr, m_base + 32'(m_off * SB));
      end
      idle_low();
   endtask

   task automatic t_len2();
      configure(32'h0000_0800, 2);
      sample("R3 len2 half");
      sample("R4 len2 end");
      sample("R3 len2 half again");
      idle_low();
   endtask

   task automatic t_buserr();
      configure(32'h0000_3000, 10);
      sample("R2 pre-error");
      sample("R2 pre-error");
      // error with simultaneous transfer: transfer discarded
      cyc(1'b1, 1'b0, 1'b1, 1'b1);
      m_frozen = 1'b1;
      chk("R5 buserr pulse", 32'(ev_buserr), 32'd1);
      chk("R5 discarded transfer", 32'(ev_count), 32'd0);
      chk("R5 addr held", cur_addr, m_base + 32'(m_off * SB));
      cyc(1'b1, 1'b0, 1'b0, 1'b0);
      chk("R5 buserr one cycle", 32'(ev_buserr), 32'd0);
      for (int i = 0; i < 3; i++) sample("R6 frozen ignores");
      // disable, then re-enable
      cyc(1'b0, 1'b0, 1'b0, 1'b0);
      m_frozen = 1'b0; m_off = 0;
      chk("R6 disable clears addr", cur_addr, m_base);
      for (int i = 0; i < 5; i++) sample("R6 resumed after re-enable");
      idle_low();
   endtask

   task automatic t_clear_prio();
      configure(32'h0000_5000, 12);
      for (int i = 0; i < 4; i++) sample("R2 before rewrite");
      cfg_base = 32'h0000_6000;
      m_base = 32'h0000_6000; m_off = 0;
      cyc(1'b1, 1'b1, 1'b1, 1'b0);
      chk("R7 wr beats done count", 32'(ev_count), 32'd0);
      chk("R7 wr clears addr", cur_addr, 32'h0000_6000);
      for (int i = 0; i < 3; i++) sample("R7 after rewrite");
      cyc(1'b0, 1'b0, 1'b1, 1'b0);
      m_off = 0;
      chk("R7 disabled done no count", 32'(ev_count), 32'd0);
      chk("R7 disable clears addr", cur_addr, m_base);
      idle_low();
   endtask

   task automatic t_bad_len();
      configure(32'h0000_7000, 5);
      for (int i = 0; i < 3; i++) sample("R8 odd length");
      configure(32'h0000_7000, 0);
      for (int i = 0; i < 2; i++) sample("R8 zero length");
      configure(32'h0000_7000, 1);
      sample("R8 length one");
      idle_low();
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(5 * 200000);
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      t_reset();
      t_full_wrap();
      t_gaps();
      t_len2();
      t_buserr();
      t_clear_prio();
      t_bad_len();
      repeat (2) @(posedge clk);
      finish_run();
   end

endmodule